// File: doc/BRIEF.md
# Per-Timeslot Blocking Strobe Generator

This block watches the bit position of two TDM serial streams, one receive and one transmit, each carrying 32 timeslots of 8 bits. A host writes a 32-bit mask for each direction. Each mask is split across four byte-wide registers. For every timeslot, the block drives a blocking strobe that is high for the whole slot when the slot's mask bit is set and low when it is clear. Downstream logic can use the strobes to gate the bit clock of an HDLC or similar controller, so that the controller only sees the chosen timeslots.

Each direction has its own bit-enable and frame-sync inputs, so receive and transmit timing run separately. All of the logic runs on one system clock. An alternate mode takes the transmit mask away from the transmit strobe and uses it to choose, per voice channel, where the transmit signaling bits come from. The choices are the internal signaling registers or an external pin: either the serial data input or a dedicated signaling input. In this mode the mask uses voice-channel numbering: 30 voice channels, with timeslots 0 and 16 skipped.

Every output is registered and loads only at the start of a timeslot. A register write or a mode change made part-way through a slot therefore does not affect that slot.

Top module: `chblk_strobe_gen`

## Requirements
- R1: After reset, `rx_blk`, `tx_blk` and `tx_sig_src` are 0. Both bit positions are at bit 0 of timeslot 0. The outputs stay 0 until the first slot start after reset.
- R2: A cycle with a bit enable and a frame sync puts that side at bit 0 of timeslot 0. A cycle with a bit enable and no frame sync advances that side by one bit. A slot is 8 bits long, and the position wraps from bit 7 of timeslot 31 to timeslot 0.
- R3: When a bit enable moves the receive side to bit 0 of timeslot t, `rx_blk` takes receive mask bit t in the next cycle and holds it for all 8 bits of the slot. Channel CHn is timeslot n-1. It is held in register (n-1)/8+1, at bit (n-1)%8.
- R4: Receive registers 1 to 4 are at host addresses 0x2B to 0x2E. Transmit registers 1 to 4 are at 0x22 to 0x25. A write to any other address changes nothing.
- R5: Receive registers affect only `rx_blk`. Transmit registers affect only `tx_blk` and `tx_sig_src`.
- R6: With `alt_sig_mode` low at a transmit slot start, `tx_blk` takes transmit mask bit t for the slot, and `tx_sig_src` is 0.
- R7: With `alt_sig_mode` high at a transmit slot start, `tx_blk` is low. Voice channel v (1 to 30) is mask bit v-1. Voice channels 1 to 15 are timeslots 1 to 15, and voice channels 16 to 30 are timeslots 17 to 31. When the voice channel's bit is set, `tx_sig_src` is 2 (register source).
- R8: In alternate mode, a timeslot whose voice bit is clear, and timeslots 0 and 16, get `tx_sig_src` = 0 (serial data input) when `sig_pin_sel` is low and 1 (signaling pin) when it is high. The value 3 never appears.
- R9: A mask write, or a change of `alt_sig_mode` or `sig_pin_sel`, made inside a slot leaves the outputs of that slot unchanged. It takes effect at the next slot start of the side concerned.
- R10: In cycles without a side's bit enable, that side's position and outputs hold. Either side can advance while the other stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| alt_sig_mode | input | 1 | 1 = transmit mask selects the signaling source |
| sig_pin_sel | input | 1 | External signaling source: 0 = serial data input, 1 = signaling pin |
| rx_bit_en | input | 1 | Receive bit-clock enable, one cycle per bit |
| rx_fsync | input | 1 | Receive frame sync, qualified by `rx_bit_en` |
| tx_bit_en | input | 1 | Transmit bit-clock enable, one cycle per bit |
| tx_fsync | input | 1 | Transmit frame sync, qualified by `tx_bit_en` |
| rx_blk | output | 1 | Receive blocking strobe |
| tx_blk | output | 1 | Transmit blocking strobe |
| tx_sig_src | output | 2 | Transmit signaling source: 0 serial data, 1 signaling pin, 2 registers |

## Verification
The bench runs full frames against several mask patterns and compares every output after every bit with a frame model kept in the bench:
- An irregular pattern separates one channel from the next.
- All-ones and all-zeros masks expose stuck outputs.
- A mask with only CH1 and CH32 set probes the wrap and the register-edge bit positions.

Alternate-mode frames are run with both pin selections. An all-ones mask proves that timeslots 0 and 16 are never chosen, and a sparse mask checks the voice-to-timeslot offset on both sides of slot 16. Further runs make writes and mode changes inside a slot, send a frame sync part-way through a frame, write to addresses outside the register map, and advance one side while the other is held. These runs separate slot-boundary loading from immediate loading, and show that the two sides are independent.

// File: rtl/chblk_pkg.sv
package chblk_pkg;

    // Transmit signaling source code driven on tx_sig_src
    typedef enum logic [1:0] {
        SRC_SERIAL = 2'b00,
        SRC_SIGPIN = 2'b01,
        SRC_REGS   = 2'b10
    } sig_src_e;

endpackage

// File: rtl/chblk_regfile.sv
module chblk_regfile #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned RX_BASE  = 'h2B,
    parameter int unsigned TX_BASE  = 'h22
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] rx_mask,
    output logic [NUM_REGS*REG_W-1:0] tx_mask
);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] rx;
        logic [NUM_REGS-1:0][REG_W-1:0] tx;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_addr == ADDR_W'(RX_BASE + i)) st_d.rx[i] = wr_data;
            if (wr_en && wr_addr == ADDR_W'(TX_BASE + i)) st_d.tx[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_mask = st_q.rx;
    assign tx_mask = st_q.tx;

    // Address decode checks
    logic in_rx, in_tx;
    assign in_rx = (wr_addr >= ADDR_W'(RX_BASE)) && (wr_addr < ADDR_W'(RX_BASE + NUM_REGS));
    assign in_tx = (wr_addr >= ADDR_W'(TX_BASE)) && (wr_addr < ADDR_W'(TX_BASE + NUM_REGS));

    a_r4_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_rx && !in_tx) |=> ($stable(rx_mask) && $stable(tx_mask)));

    a_r5_rx_write_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_rx) |=> $stable(tx_mask));

    a_r5_tx_write_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_tx) |=> $stable(rx_mask));

endmodule

// File: rtl/chblk_slot_tracker.sv
module chblk_slot_tracker #(
    parameter int unsigned NUM_SLOTS     = 32,
    parameter int unsigned BITS_PER_SLOT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_en,
    input  logic                         fsync,
    output logic                         load,
    output logic [$clog2(NUM_SLOTS)-1:0] next_slot
);

    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);
    localparam int unsigned BIT_W  = $clog2(BITS_PER_SLOT);
    localparam int unsigned POS_W  = SLOT_W + BIT_W;

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t             st_d, st_q;
    logic [POS_W-1:0] pos_nxt;

    always_comb begin
        st_d    = st_q;
        pos_nxt = fsync ? '0 : POS_W'(st_q.pos + 1'b1);
        if (bit_en) st_d.pos = pos_nxt;
        load      = bit_en && (pos_nxt[BIT_W-1:0] == '0);
        next_slot = pos_nxt[POS_W-1:BIT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_fsync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fsync) |=> (st_q.pos == '0));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !fsync) |=> (st_q.pos == POS_W'($past(st_q.pos) + 1'b1)));

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(st_q.pos));

endmodule

// File: rtl/chblk_strobe_gen.sv
module chblk_strobe_gen #(
    parameter int unsigned NUM_SLOTS     = 32,
    parameter int unsigned BITS_PER_SLOT = 8,
    parameter int unsigned REG_W         = 8,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned RX_BASE       = 'h2B,
    parameter int unsigned TX_BASE       = 'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    input  logic              alt_sig_mode,
    input  logic              sig_pin_sel,
    input  logic              rx_bit_en,
    input  logic              rx_fsync,
    input  logic              tx_bit_en,
    input  logic              tx_fsync,
    output logic              rx_blk,
    output logic              tx_blk,
    output logic [1:0]        tx_sig_src
);

    import chblk_pkg::*;

    localparam int unsigned NUM_REGS = NUM_SLOTS / REG_W;
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS);
    localparam int unsigned HALF     = NUM_SLOTS / 2;
    localparam int unsigned SIDE_RX  = 0;
    localparam int unsigned SIDE_TX  = 1;

    logic [NUM_SLOTS-1:0] rx_mask, tx_mask;

    chblk_regfile #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .RX_BASE  (RX_BASE),
        .TX_BASE  (TX_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_en),
        .wr_addr (host_addr),
        .wr_data (host_wdata),
        .rx_mask (rx_mask),
        .tx_mask (tx_mask)
    );

    // One slot tracker per direction
    logic [1:0]        side_bit_en, side_fsync, side_load;
    logic [SLOT_W-1:0] side_slot [2];

    assign side_bit_en = {tx_bit_en, rx_bit_en};
    assign side_fsync  = {tx_fsync, rx_fsync};

    for (genvar g = 0; g < 2; g++) begin : g_side
        chblk_slot_tracker #(
            .NUM_SLOTS     (NUM_SLOTS),
            .BITS_PER_SLOT (BITS_PER_SLOT)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_en    (side_bit_en[g]),
            .fsync     (side_fsync[g]),
            .load      (side_load[g]),
            .next_slot (side_slot[g])
        );
    end

    // Voice-channel view of the transmit mask: slots 0 and HALF carry no voice
    function automatic logic voice_pick(input logic [SLOT_W-1:0] ts,
                                        input logic [NUM_SLOTS-1:0] m);
        int unsigned t;
        t = int'(ts);
        if (t == 0 || t == HALF) return 1'b0;
        else if (t < HALF)       return m[t-1];
        else                     return m[t-2];
    endfunction

    typedef struct packed {
        logic     rx_blk;
        logic     tx_blk;
        sig_src_e src;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (side_load[SIDE_RX]) o_d.rx_blk = rx_mask[side_slot[SIDE_RX]];
        if (side_load[SIDE_TX]) begin
            if (alt_sig_mode) begin
                o_d.tx_blk = 1'b0;
                if (voice_pick(side_slot[SIDE_TX], tx_mask)) o_d.src = SRC_REGS;
                else if (sig_pin_sel)                        o_d.src = SRC_SIGPIN;
                else                                         o_d.src = SRC_SERIAL;
            end else begin
                o_d.tx_blk = tx_mask[side_slot[SIDE_TX]];
                o_d.src    = SRC_SERIAL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '{rx_blk: 1'b0, tx_blk: 1'b0, src: SRC_SERIAL};
        else        o_q <= o_d;
    end

    assign rx_blk     = o_q.rx_blk;
    assign tx_blk     = o_q.tx_blk;
    assign tx_sig_src = o_q.src;

    a_r9_rx_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_blk) |-> $past(side_load[SIDE_RX]));

    a_r9_tx_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tx_blk) || !$stable(tx_sig_src)) |-> $past(side_load[SIDE_TX]));

    a_r6_normal_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (side_load[SIDE_TX] && !alt_sig_mode) |=> (tx_sig_src == 2'b00));

    a_r7_alt_blk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (side_load[SIDE_TX] && alt_sig_mode) |=> !tx_blk);

    a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sig_src != 2'b11);

endmodule

// File: tb/sim_chblk_strobe_gen.sv
module sim_chblk_strobe_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       alt_sig_mode = 1'b0;
    logic       sig_pin_sel = 1'b0;
    logic       rx_bit_en = 1'b0, rx_fsync = 1'b0;
    logic       tx_bit_en = 1'b0, tx_fsync = 1'b0;
    logic       rx_blk, tx_blk;
    logic [1:0] tx_sig_src;

    always #4 clk = ~clk;   // 125 MHz

    chblk_strobe_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .alt_sig_mode (alt_sig_mode),
        .sig_pin_sel  (sig_pin_sel),
        .rx_bit_en    (rx_bit_en),
        .rx_fsync     (rx_fsync),
        .tx_bit_en    (tx_bit_en),
        .tx_fsync     (tx_fsync),
        .rx_blk       (rx_blk),
        .tx_blk       (tx_blk),
        .tx_sig_src   (tx_sig_src)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R1";

    // Bench frame model
    logic [31:0] m_rx = '0, m_tx = '0;
    int          rpos = 0, tpos = 0;
    logic        e_rx = 0, e_tx = 0;
    logic [1:0]  e_src = 0;

    function automatic logic voice_bit(int t, logic [31:0] m);
        if (t >= 1 && t <= 15)  return m[t-1];
        if (t >= 17 && t <= 31) return m[t-2];
        return 1'b0;
    endfunction

    task automatic check(string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at rpos=%0d tpos=%0d: actual=%0d expected=%0d",
                     req, what, rpos, tpos, act, exp);
        end
    endtask

    task automatic check_all();
        check("rx_blk", {1'b0, rx_blk}, {1'b0, e_rx});
        check("tx_blk", {1'b0, tx_blk}, {1'b0, e_tx});
        check("tx_sig_src", tx_sig_src, e_src);
    endtask

    // One bit step: inputs set at negedge, result checked at the next negedge
    task automatic step(bit rgo, bit tgo, bit rfs, bit tfs);
        @(negedge clk);
        rx_bit_en = rgo; rx_fsync = rfs;
        tx_bit_en = tgo; tx_fsync = tfs;
        @(negedge clk);
        rx_bit_en = 0; rx_fsync = 0; tx_bit_en = 0; tx_fsync = 0;
        if (rgo) begin
            rpos = rfs ? 0 : (rpos + 1) % 256;
            if (rpos % 8 == 0) e_rx = m_rx[rpos/8];
        end
        if (tgo) begin
            tpos = tfs ? 0 : (tpos + 1) % 256;
            if (tpos % 8 == 0) begin
                if (alt_sig_mode) begin
                    e_tx  = 0;
                    e_src = voice_bit(tpos/8, m_tx) ? 2'd2 : (sig_pin_sel ? 2'd1 : 2'd0);
                end else begin
                    e_tx  = m_tx[tpos/8];
                    e_src = 2'd0;
                end
            end
        end
        check_all();
    endtask

    task automatic run(int n, bit rgo, bit tgo, bit fs_first);
        for (int i = 0; i < n; i++) step(rgo, tgo, fs_first && i == 0, fs_first && i == 0);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        host_wr_en = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 0;
        if (a >= 8'h2B && a <= 8'h2E) m_rx[(a-8'h2B)*8 +: 8] = d;   // R4 map
        if (a >= 8'h22 && a <= 8'h25) m_tx[(a-8'h22)*8 +: 8] = d;
    endtask

    task automatic wr_masks(logic [31:0] r, logic [31:0] t);
        for (int k = 0; k < 4; k++) begin
            wr(8'(8'h2B + k), r[k*8 +: 8]);
            wr(8'(8'h22 + k), t[k*8 +: 8]);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        req = "R1"; check_all();
        // R1/R2: bits 1..7 of slot 0 without sync, then slot 1 start
        req = "R2"; run(8, 1, 1, 0);

        // R3/R6: irregular masks, normal mode, full frames
        req = "R3"; wr_masks(32'hA5C3_0F71, 32'h3C96_E11B);
        run(256 + 40, 1, 1, 1);
        req = "R6"; wr_masks(32'hFFFF_FFFF, 32'h0000_0000); run(260, 1, 1, 1);
        req = "R6"; wr_masks(32'h0000_0000, 32'hFFFF_FFFF); run(260, 1, 1, 1);
        req = "R3"; wr_masks(32'h8000_0001, 32'h8000_0001); run(260, 1, 1, 1);

        // R4: writes outside the map change nothing
        req = "R4";
        wr(8'h21, 8'hFF); wr(8'h26, 8'hFF); wr(8'h2A, 8'hFF); wr(8'h2F, 8'hFF); wr(8'h00, 8'hFF);
        run(260, 1, 1, 1);

        // R5: rx-only writes leave tx outputs, tx-only leave rx
        req = "R5"; wr(8'h2C, 8'h5A); run(130, 1, 1, 1);
        wr(8'h24, 8'hC3); run(260, 1, 1, 0);

        // R7/R8: alternate mode, both pin selections
        alt_sig_mode = 1;
        req = "R7"; wr_masks(32'h1234_5678, 32'hFFFF_FFFF); sig_pin_sel = 0; run(260, 1, 1, 1);
        req = "R8"; sig_pin_sel = 1; run(260, 1, 1, 1);
        req = "R7"; wr_masks(32'h1234_5678, 32'h2000_C001); sig_pin_sel = 0; run(260, 1, 1, 1);
        req = "R8"; wr_masks(32'h1234_5678, 32'h5A5A_A5A5); sig_pin_sel = 1; run(260, 1, 1, 1);

        // R9: mid-slot writes and mode changes wait for the next slot start
        req = "R9"; run(19, 1, 1, 1);
        wr(8'h2B, 8'hF0); wr(8'h22, 8'h0F);
        run(3, 1, 1, 0);
        alt_sig_mode = 0; run(2, 1, 1, 0);
        sig_pin_sel = 0; run(20, 1, 1, 0);
        alt_sig_mode = 1; run(3, 1, 1, 0);
        wr_masks(32'h0F0F_0F0F, 32'hF0F0_F0F0); run(60, 1, 1, 0);
        alt_sig_mode = 0;

        // R2: sync part-way through a frame realigns
        req = "R2"; run(77, 1, 1, 0); step(1, 1, 1, 1); run(40, 1, 1, 0);
        step(1, 0, 1, 0); run(30, 1, 1, 0);

        // R10: one side idle while the other runs; idle clocks hold outputs
        req = "R10"; run(100, 1, 0, 0); run(100, 0, 1, 0);
        for (int i = 0; i < 20; i++) begin @(negedge clk); check_all(); end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule